// File: doc/BRIEF.md
# Paper-Tape Read-In Word Loader

This block sits between a byte source that delivers paper-tape frames and a 4096-word memory. It takes each 8-bit frame through a valid/ready handshake and decodes the tape in the simplest read-in layout. Every frame carries six payload bits. Two frames in a row make one 12-bit word. The first frame of the pair also says whether the word is a load address or a data word. Frames punched in the top channel are blank leader or trailer and are skipped.

An address word is kept in an internal register, which is driven straight onto the memory address output. A data word causes one single-cycle write of that word at the held address. The address does not advance afterwards, so every data word on the tape is preceded by its own address pair. The tape has no end mark. Loading goes on until the halt input is raised. A malformed second frame sets a sticky error flag.

Top module: `tape_word_loader`

## Requirements
- R1: A frame with bit 7 set, accepted while no partial word is held, changes no state and causes no memory write.
- R2: A word is built from two accepted non-leader frames. Bits 5..0 of the first frame become word bits 11..6, and bits 5..0 of the second frame become word bits 5..0.
- R3: When bit 6 of the first frame is set, the completed word becomes the load address. It appears on mem_addr one cycle after the second frame is accepted, and no write is issued.
- R4: When bit 6 of the first frame is clear, the completed word is written at the held load address. The load address is never incremented by a write.
- R5: A frame with bit 7 set, accepted while a first frame is held, discards the partial word. The next non-leader frame is then taken as a first frame.
- R6: A write is a mem_we pulse exactly one cycle long, in the cycle after the second frame is accepted, with mem_addr and mem_data valid in that cycle. frame_ready is low during that cycle.
- R7: A second frame with bit 7 clear and bit 6 set sets format_error, drops the partial word and writes nothing. format_error stays set until reset.
- R8: While halt is high, frame_ready is low and no frame is accepted.
- R9: Synchronous reset clears the load address to 0, clears the pair state and format_error, and leaves mem_we low and frame_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Stops frame acceptance while high |
| frame_valid | input | 1 | Source offers a frame |
| frame_data | input | 8 | Tape frame: bit 7 leader, bit 6 address tag, bits 5..0 payload |
| frame_ready | output | 1 | Block accepts the offered frame this cycle |
| mem_addr | output | 12 | Held load address |
| mem_data | output | 12 | Word being written |
| mem_we | output | 1 | One-cycle write strobe |
| format_error | output | 1 | Sticky malformed-pair flag |

## Verification
The bench goes after a leader frame that lands inside a pair. A design that did not abort there would join the next frame to a stale upper half and write a wrong word. It repeats data pairs without new addresses, which exposes a design that increments the address by mistake. It sends second frames with the tag bit set, where a weak design would write garbage or let the error flag clear itself. It also holds a frame under halt, where accepting it would shift the pairing of every word after it.

// File: rtl/tape_load_pkg.sv
package tape_load_pkg;
   typedef enum logic [1:0] {
      FK_PLAIN  = 2'd0,
      FK_TAGGED = 2'd1,
      FK_LEADER = 2'd2
   } frame_kind_t;
endpackage

// File: rtl/tape_frame_sorter.sv
module tape_frame_sorter
   import tape_load_pkg::*;
#(
   parameter int PAYLOAD_W = 6,
   localparam int FRAME_W  = PAYLOAD_W + 2
) (
   input  logic [FRAME_W-1:0]   frame,
   output frame_kind_t          kind,
   output logic [PAYLOAD_W-1:0] payload
);
   localparam int LEAD_BIT = PAYLOAD_W + 1;
   localparam int TAG_BIT  = PAYLOAD_W;

   always_comb begin
      payload = frame[PAYLOAD_W-1:0];
      if (frame[LEAD_BIT])
         kind = FK_LEADER;
      else if (frame[TAG_BIT])
         kind = FK_TAGGED;
      else
         kind = FK_PLAIN;
   end
endmodule

// File: rtl/tape_pair_joiner.sv
module tape_pair_joiner
   import tape_load_pkg::*;
#(
   parameter int PAYLOAD_W = 6,
   localparam int WORD_W   = 2 * PAYLOAD_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 accept,
   input  frame_kind_t          kind,
   input  logic [PAYLOAD_W-1:0] payload,
   output logic                 word_done,
   output logic                 word_is_addr,
   output logic [WORD_W-1:0]    word,
   output logic                 bad_second
);
   logic                 have_q;
   logic                 tag_q;
   logic [PAYLOAD_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_q <= 1'b0;
         tag_q  <= 1'b0;
         hi_q   <= '0;
      end else if (accept) begin
         if (kind == FK_LEADER) begin
            have_q <= 1'b0;
         end else if (!have_q) begin
            have_q <= 1'b1;
            hi_q   <= payload;
            tag_q  <= (kind == FK_TAGGED);
         end else begin
            have_q <= 1'b0;
         end
      end
   end

   always_comb begin
      word_done    = accept && have_q && (kind == FK_PLAIN);
      bad_second   = accept && have_q && (kind == FK_TAGGED);
      word         = {hi_q, payload};
      word_is_addr = tag_q;
   end

   // R5: a leader frame inside a pair leaves no half word behind
   a_r5_leader_aborts: assert property (@(posedge clk) disable iff (rst)
      (accept && kind == FK_LEADER) |=> !have_q);
endmodule

// File: rtl/tape_write_stage.sv
module tape_write_stage #(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_done,
   input  logic              word_is_addr,
   input  logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_data,
   output logic              mem_we
);
   logic [WORD_W-1:0] addr_q;
   logic [WORD_W-1:0] data_q;
   logic              pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         data_q <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= word_done && !word_is_addr;
         if (word_done && word_is_addr)
            addr_q <= word;
         if (word_done && !word_is_addr)
            data_q <= word;
      end
   end

   assign mem_addr = addr_q;
   assign mem_data = data_q;
   assign mem_we   = pend_q;

   // R3/R4: the load address moves only on a completed address word
   a_r4_addr_only_on_tag: assert property (@(posedge clk) disable iff (rst)
      !(word_done && word_is_addr) |=> $stable(addr_q));
endmodule

// File: rtl/tape_word_loader.sv
module tape_word_loader
   import tape_load_pkg::*;
#(
   parameter int PAYLOAD_W = 6,
   localparam int FRAME_W  = PAYLOAD_W + 2,
   localparam int WORD_W   = 2 * PAYLOAD_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               halt,
   input  logic               frame_valid,
   input  logic [FRAME_W-1:0] frame_data,
   output logic               frame_ready,
   output logic [WORD_W-1:0]  mem_addr,
   output logic [WORD_W-1:0]  mem_data,
   output logic               mem_we,
   output logic               format_error
);
   generate
      if (PAYLOAD_W < 1) begin : g_bad_width
         $error("tape_word_loader: PAYLOAD_W must be at least 1");
      end
   endgenerate

   frame_kind_t          kind;
   logic [PAYLOAD_W-1:0] payload;
   logic                 accept;
   logic                 word_done;
   logic                 word_is_addr;
   logic [WORD_W-1:0]    word;
   logic                 bad_second;
   logic                 err_q;

   assign frame_ready  = !halt && !mem_we;
   assign accept       = frame_valid && frame_ready;
   assign format_error = err_q;

   tape_frame_sorter #(.PAYLOAD_W(PAYLOAD_W)) u_sort (
      .frame   (frame_data),
      .kind    (kind),
      .payload (payload)
   );

   tape_pair_joiner #(.PAYLOAD_W(PAYLOAD_W)) u_join (
      .clk          (clk),
      .rst          (rst),
      .accept       (accept),
      .kind         (kind),
      .payload      (payload),
      .word_done    (word_done),
      .word_is_addr (word_is_addr),
      .word         (word),
      .bad_second   (bad_second)
   );

   tape_write_stage #(.WORD_W(WORD_W)) u_wr (
      .clk          (clk),
      .rst          (rst),
      .word_done    (word_done),
      .word_is_addr (word_is_addr),
      .word         (word),
      .mem_addr     (mem_addr),
      .mem_data     (mem_data),
      .mem_we       (mem_we)
   );

   always_ff @(posedge clk) begin
      if (rst)
         err_q <= 1'b0;
      else if (bad_second)
         err_q <= 1'b1;
   end

   a_r8_halt_blocks: assert property (@(posedge clk) disable iff (rst)
      halt |-> !frame_ready);
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);
   a_r6_ready_low_on_write: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> !frame_ready);
   a_r7_error_sticky: assert property (@(posedge clk) disable iff (rst)
      format_error |=> format_error);
   a_r4_addr_held_after_write: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> $stable(mem_addr));
   a_r1_leader_no_write: assert property (@(posedge clk) disable iff (rst)
      (accept && frame_data[FRAME_W-1]) |=> !mem_we);
endmodule

// File: tb/tb_tape_word_loader.sv
module tb_tape_word_loader;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        halt = 1'b0;
   logic        frame_valid = 1'b0;
   logic [7:0]  frame_data = 8'h00;
   logic        frame_ready;
   logic [11:0] mem_addr;
   logic [11:0] mem_data;
   logic        mem_we;
   logic        format_error;

   always #4 clk = ~clk;

   tape_word_loader dut (
      .clk(clk), .rst(rst), .halt(halt), .frame_valid(frame_valid),
      .frame_data(frame_data), .frame_ready(frame_ready), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_we(mem_we), .format_error(format_error)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // behavioural reference state
   int m_addr = 0, m_data = 0, m_we = 0, m_err = 0;
   int m_have = 0, m_hi = 0, m_tag = 0;

   always @(posedge clk) begin
      int acc, nwe;
      if (rst) begin
         m_addr = 0; m_data = 0; m_we = 0; m_err = 0;
         m_have = 0; m_hi = 0; m_tag = 0;
      end else begin
         acc = frame_valid && !halt && !m_we;
         nwe = 0;
         if (acc) begin
            if (frame_data[7]) m_have = 0;
            else if (!m_have) begin
               m_have = 1; m_hi = frame_data[5:0]; m_tag = frame_data[6];
            end else begin
               m_have = 0;
               if (frame_data[6]) m_err = 1;
               else if (m_tag) m_addr = m_hi * 64 + frame_data[5:0];
               else begin m_data = m_hi * 64 + frame_data[5:0]; nwe = 1; end
            end
         end
         m_we = nwe;
      end
   end

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   int wr_count = 0, last_a = 0, last_d = 0;
   always @(negedge clk) begin
      #2;
      if (!rst && !finished) begin
         chk("R6 mem_we", mem_we, m_we);
         chk("R3 mem_addr", mem_addr, m_addr);
         if (m_we) chk("R2 mem_data", mem_data, m_data);
         chk("R7 format_error", format_error, m_err);
         chk("R8 frame_ready", frame_ready, (!halt && !m_we) ? 1 : 0);
         if (mem_we) begin wr_count++; last_a = mem_addr; last_d = mem_data; end
      end
   end

   // called at a falling edge; returns at a falling edge after acceptance
   task automatic send(input logic [7:0] b);
      bit ok;
      frame_valid = 1'b1;
      frame_data  = b;
      do begin
         #1 ok = frame_ready;
         @(negedge clk);
      end while (!ok);
      frame_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int wc;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R9 reset ready", frame_ready, 1);
      chk("R9 reset addr", mem_addr, 0);
      chk("R9 reset err", format_error, 0);
      chk("R9 reset we", mem_we, 0);
      @(negedge clk);

      // R1: lone leader frames
      send(8'h80); send(8'hFF); idle(2);
      chk("R1 addr after leader", mem_addr, 0);
      chk("R1 no write on leader", wr_count, 0);

      // R3/R2: address pair
      send(8'h52); send(8'h34); idle(2);
      chk("R3 address loaded", mem_addr, 12'h4B4);
      chk("R3 no write on address", wr_count, 0);

      // R4: data pair written at held address
      send(8'h05); send(8'h2A); idle(3);
      chk("R4 write count", wr_count, 1);
      chk("R4 write addr", last_a, 12'h4B4);
      chk("R2 write data", last_d, 12'h16A);

      // R4: second data word, no increment
      send(8'h3F); send(8'h3F); idle(3);
      chk("R4 no increment addr", last_a, 12'h4B4);
      chk("R4 second data", last_d, 12'hFFF);
      chk("R4 addr register held", mem_addr, 12'h4B4);

      // R5: leader inside a pair aborts it
      send(8'h41); send(8'h80); send(8'h02); send(8'h03); idle(3);
      chk("R5 abort then data", last_d, 12'h083);
      chk("R5 addr unchanged", mem_addr, 12'h4B4);
      chk("R5 write count", wr_count, 3);

      // R8: halt blocks acceptance
      halt = 1'b1; frame_valid = 1'b1; frame_data = 8'h7F;
      repeat (4) begin
         #1 chk("R8 ready low under halt", frame_ready, 0);
         @(negedge clk);
      end
      frame_valid = 1'b0; halt = 1'b0;
      send(8'h01); send(8'h01); idle(3);
      chk("R8 halted frame not taken", last_d, 12'h041);
      chk("R8 addr kept", mem_addr, 12'h4B4);

      // R7: tagged second frame
      wc = wr_count;
      send(8'h01); send(8'h45); idle(3);
      chk("R7 error set", format_error, 1);
      chk("R7 no write", wr_count, wc);
      chk("R7 addr kept", mem_addr, 12'h4B4);
      send(8'h00); send(8'h07); idle(3);
      chk("R7 recovers data", last_d, 12'h007);
      chk("R7 error sticky", format_error, 1);

      // mixed random stream, reference model compares every cycle
      for (int i = 0; i < 600; i++) begin
         int r;
         logic [7:0] b;
         r = $urandom % 10;
         if (r < 2) b = 8'h80 | 8'($urandom % 128);
         else if (r < 4) b = 8'h40 | 8'($urandom % 64);
         else if (r < 5) b = 8'($urandom % 256);
         else b = 8'($urandom % 64);
         if (($urandom % 8) == 0) begin
            halt = 1'b1; idle(1 + $urandom % 3); halt = 1'b0;
         end
         send(b);
         if (($urandom % 4) == 0) idle(1);
      end
      idle(3);

      // R9: reset mid-run
      rst = 1'b1; idle(2); rst = 1'b0; #1;
      chk("R9 reset addr again", mem_addr, 0);
      chk("R9 reset err again", format_error, 0);
      chk("R9 reset ready again", frame_ready, 1);
      @(negedge clk);
      send(8'h05); send(8'h06); idle(3);
      chk("R9 pair state cleared", last_a, 0);
      chk("R9 data after reset", last_d, 12'h146);

      summary();
   end
endmodule